// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with one 32-bit control word on a plain single-register read/write port, all in one clock domain. Once enabled, an internal counter climbs every clock. When it reaches a power-of-two interval picked by a 3-bit select, an interrupt flag is raised. If software still has not restarted the counter 1024 clocks after that, a one-cycle reset pulse is issued for a system reset controller to act on.

Software services the timer by writing 1 to the restart bit. The two status flags are write-1-to-clear, and the restart bit clears itself after a short hold. Turning the enable off stops the timer and returns the counter to zero. After a reset request the counter parks at its final value, so a second pulse can only follow a restart or a disable and re-enable.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word reads 0x0000_0000 and both `irqOut` and `rstPulse` are low.
- R2: Control word fields: bit 0 is restart, bit 1 is reset enable, bit 2 is the reset flag, bit 3 is the interrupt flag, bit 6 is interrupt enable, bit 7 is timer enable, and bits 10:8 are the interval select `sel`. Bits 1, 6, 7 and 10:8 read back as written. Every other bit reads 0.
- R3: If a write sets the timer enable at clock edge E, the interrupt flag (bit 3) becomes 1 at edge E+T, where T = 2^(2*sel+4). It is still 0 after edge E+T-1. This happens whatever the interrupt enable is.
- R4: `irqOut` equals the interrupt flag ANDed with interrupt enable (bit 6).
- R5: With reset enable at 1 and no restart, `rstPulse` is high for exactly the one cycle after edge E+T+1024. The reset flag (bit 2) sets at that same edge. The counter then holds, so no further pulse follows.
- R6: With reset enable at 0, the timer never raises `rstPulse` and never sets the reset flag.
- R7: Writing 1 to bit 2 or bit 3 clears that flag. Writing 0 to either leaves it unchanged.
- R8: A write with bit 0 set at edge W makes bit 0 read 1 after edges W and W+1, and 0 after edge W+2. The counter is zero and held during that time, so the interrupt flag next sets at edge W+2+T. Writing 0 to bit 0 has no effect.
- R9: Clearing the timer enable resets the counter to zero. A later enable starts a full new interval.
- R10: If a hardware set of the interrupt flag and a write-1-to-clear of it land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the counter |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current control word readback |
| irqOut | output | 1 | Level interrupt request |
| rstPulse | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `wrEn` and `wrData` change only between clock edges. They also assume that the interval select is not lowered while the counter runs past the new limit, because that would make the counter wrap before it reaches the reset point. The stimulus drives every write on the falling edge. It changes `sel` only in the same write that turns the timer on from a disabled state, when the counter is already zero. Intervals are swept for selects 0 through 5, and the edge timing of each interval is worked out arithmetically in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Field positions in the control word.
  localparam int B_RESTART = 0;
  localparam int B_RSTEN   = 1;
  localparam int B_RSTFLAG = 2;
  localparam int B_IRQFLAG = 3;
  localparam int B_IRQEN   = 6;
  localparam int B_EN      = 7;
  localparam int B_SEL_LO  = 8;

  // Strobes from control to the counter datapath.
  typedef struct packed {
    logic run;
    logic clear;
  } cntCtl_t;

  // Events reported back by the datapath.
  typedef struct packed {
    logic irqHit;
    logic rstHit;
    logic atEnd;
  } cntEvt_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int DELAY = 1024,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic [SEL_W-1:0] sel,
  output cntEvt_t          evt
);
  localparam int N_SEL = 2 ** SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] limIrq;
  logic [CNT_W-1:0] limRst;

  always_comb begin
    limIrq = '0;
    for (int i = 0; i < N_SEL; i++) begin
      if (sel == SEL_W'(i)) limIrq = CNT_W'(1) << (2 * i + 4);
    end
    limRst  = limIrq + CNT_W'(DELAY);
    cntNext = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (ctl.clear) cnt <= '0;
    else if (ctl.run)   cnt <= cntNext;
  end

  always_comb begin
    evt.irqHit = ctl.run && !ctl.clear && (cntNext == limIrq);
    evt.rstHit = ctl.run && !ctl.clear && (cntNext == limRst);
    evt.atEnd  = (cnt == limRst);
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int HOLD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  cntEvt_t           evt,
  output cntCtl_t           ctl,
  output logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstPulse
);
  localparam int HOLD_W = $clog2(HOLD + 1);

  logic              enReg, rstEnReg, irqEnReg;
  logic              irqFlag, rstFlag;
  logic [HOLD_W-1:0] holdCnt;
  logic              holding, restartReq;

  assign holding    = (holdCnt != '0);
  assign restartReq = wrEn && wrData[B_RESTART];

  always_comb begin
    ctl.clear = !enReg || restartReq || holding;
    ctl.run   = enReg && !holding && !evt.atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      rstEnReg <= 1'b0;
      irqEnReg <= 1'b0;
      sel      <= '0;
    end else if (wrEn) begin
      enReg    <= wrData[B_EN];
      rstEnReg <= wrData[B_RSTEN];
      irqEnReg <= wrData[B_IRQEN];
      sel      <= wrData[B_SEL_LO +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           holdCnt <= '0;
    else if (restartReq) holdCnt <= HOLD_W'(HOLD);
    else if (holding)    holdCnt <= holdCnt - HOLD_W'(1);
  end

  // Hardware set wins over a same-edge write-1-to-clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag  <= 1'b0;
      rstFlag  <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      irqFlag  <= (irqFlag && !(wrEn && wrData[B_IRQFLAG])) || evt.irqHit;
      rstFlag  <= (rstFlag && !(wrEn && wrData[B_RSTFLAG])) ||
                  (evt.rstHit && rstEnReg);
      rstPulse <= evt.rstHit && rstEnReg;
    end
  end

  always_comb begin
    rdData                       = '0;
    rdData[B_RESTART]            = holding;
    rdData[B_RSTEN]              = rstEnReg;
    rdData[B_RSTFLAG]            = rstFlag;
    rdData[B_IRQFLAG]            = irqFlag;
    rdData[B_IRQEN]              = irqEnReg;
    rdData[B_EN]                 = enReg;
    rdData[B_SEL_LO +: SEL_W]    = sel;
    irqOut                       = irqFlag && irqEnReg;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int DELAY  = 1024,
  parameter int HOLD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstPulse
);
  localparam int MAX_EXP = 2 * (2 ** SEL_W - 1) + 4;
  localparam int CNT_W   = MAX_EXP + 2;

  cntCtl_t          ctl;
  cntEvt_t          evt;
  logic [SEL_W-1:0] sel;

  wdog_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .HOLD(HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .evt(evt),
    .ctl(ctl), .sel(sel), .rdData(rdData), .irqOut(irqOut),
    .rstPulse(rstPulse)
  );

  wdog_counter #(.SEL_W(SEL_W), .DELAY(DELAY), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sel(sel), .evt(evt)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic              rstPulse
);
  // R5: reset request lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse);

  // R6: a pulse only happens with reset enable on
  a_r6_pulse_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> $past(rdData[1]));

  // R4: interrupt output follows flag and enable
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rdData[3] && rdData[6]));

  // R8: restart write shows up on bit 0
  a_r8_restart_seen: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0]) |=> rdData[0]);

  // R7: interrupt flag is sticky without a write-1-to-clear
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[3] && !(wrEn && wrData[3])) |=> rdData[3]);

  // R2: unused bits read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[5:4] == 2'b00) && (rdData[DATA_W-1:11] == '0));
endmodule

bind wdog_timer wdog_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irqOut(irqOut), .rstPulse(rstPulse)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, rstPulse;

  int cyc = 0;
  int pulses = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstPulse) pulses <= pulses + 1;
  end

  wdog_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .rstPulse(rstPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Write lands on the next rising edge; returns at the following falling edge.
  task automatic wr(input logic [31:0] d, output int edgeAt);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    edgeAt = cyc;
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int cfg(input bit en, input bit rEn, input bit iEn, input int s);
    return (int'(en) << 7) | (int'(iEn) << 6) | (int'(rEn) << 1) | (s << 8);
  endfunction

  initial begin
    int e, w, p0, tt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 32'h0, "R1", rdData, 0);
    check(!irqOut && !rstPulse, "R1", {irqOut, rstPulse}, 0);

    // R2: field readback, unused bits zero
    wr(32'hFFFF_FFF2, e);
    check(rdData == 32'h0000_07C2, "R2", rdData, 32'h7C2);
    wr(32'h0, e);
    check(rdData == 32'h0, "R2", rdData, 0);

    // R3/R4/R5 sweep over interval selects
    for (int s = 0; s <= 5; s++) begin
      tt = 1 << (2 * s + 4);
      wr(32'h0, e);
      wr(32'hC, e);
      p0 = pulses;
      wr(cfg(1, 1, 0, s), e);
      waitTo(e + tt - 1);
      check(rdData[3] == 1'b0, "R3", rdData[3], 0);
      waitTo(e + tt);
      check(rdData[3] == 1'b1, "R3", rdData[3], 1);
      check(irqOut == 1'b0, "R4", irqOut, 0);
      waitTo(e + tt + 1023);
      check(rstPulse == 1'b0 && rdData[2] == 1'b0, "R5", {rstPulse, rdData[2]}, 0);
      waitTo(e + tt + 1024);
      check(rstPulse == 1'b1, "R5", rstPulse, 1);
      check(rdData[2] == 1'b1, "R5", rdData[2], 1);
      waitTo(e + tt + 1025);
      check(rstPulse == 1'b0, "R5", rstPulse, 0);
      waitTo(e + tt + 1300);
      check(pulses - p0 == 1, "R5", pulses - p0, 1);
    end

    // R4: enabling the interrupt exposes the pending flag
    wr(cfg(1, 1, 1, 5), e);
    check(irqOut == 1'b1, "R4", irqOut, 1);

    // R7: write 0 keeps flags, write 1 clears each
    wr(cfg(1, 1, 1, 5), e);
    check(rdData[3:2] == 2'b11, "R7", rdData[3:2], 3);
    wr(cfg(1, 1, 1, 5) | 32'h8, e);
    check(rdData[3:2] == 2'b01, "R7", rdData[3:2], 1);
    check(irqOut == 1'b0, "R7", irqOut, 0);
    wr(cfg(1, 1, 1, 5) | 32'h4, e);
    check(rdData[3:2] == 2'b00, "R7", rdData[3:2], 0);

    // R6: reset disabled, no pulse and no flag
    wr(32'h0, e);
    p0 = pulses;
    wr(cfg(1, 0, 0, 0), e);
    waitTo(e + 16 + 1100);
    check(pulses == p0, "R6", pulses - p0, 0);
    check(rdData[2] == 1'b0, "R6", rdData[2], 0);
    check(rdData[3] == 1'b1, "R6", rdData[3], 1);

    // R8: restart hold and interval restart
    wr(32'h0, e);
    wr(32'hC, e);
    wr(cfg(1, 0, 0, 0), e);
    waitTo(e + 5);
    wr(cfg(1, 0, 0, 0) | 32'h1, w);
    check(rdData[0] == 1'b1, "R8", rdData[0], 1);
    waitTo(w + 1);
    check(rdData[0] == 1'b1, "R8", rdData[0], 1);
    waitTo(w + 2);
    check(rdData[0] == 1'b0, "R8", rdData[0], 0);
    waitTo(w + 2 + 15);
    check(rdData[3] == 1'b0, "R8", rdData[3], 0);
    waitTo(w + 2 + 16);
    check(rdData[3] == 1'b1, "R8", rdData[3], 1);

    // R9: disable clears the count
    wr(32'h0, e);
    wr(32'hC, e);
    wr(cfg(1, 0, 0, 1), e);
    waitTo(e + 40);
    wr(32'h0, e);
    waitTo(e + 3);
    wr(cfg(1, 0, 0, 1), e);
    waitTo(e + 63);
    check(rdData[3] == 1'b0, "R9", rdData[3], 0);
    waitTo(e + 64);
    check(rdData[3] == 1'b1, "R9", rdData[3], 1);

    // R10: clear lands on the same edge as the hardware set
    wr(32'h0, e);
    wr(32'hC, e);
    wr(cfg(1, 0, 1, 0), e);
    waitTo(e + 15);
    wrEn = 1'b1; wrData = cfg(1, 0, 1, 0) | 32'h8;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    check(cyc == e + 16, "R10", cyc, e + 16);
    check(rdData[3] == 1'b1, "R10", rdData[3], 1);
    check(irqOut == 1'b1, "R10", irqOut, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule